// File: doc/BRIEF.md
# SMBASE Lockable SMRAM Guard Register

This block holds a one-byte configuration register that firmware uses to claim and then seal a protected RAM window at the default SMBASE area. After reset the register is in an open mode in which every written value is thrown away. Firmware first writes a query code. The register answers with an acknowledge code and moves to a negotiated mode. In that mode only the lock bit can be written. Setting the lock bit seals the window and takes the lock bit out of the write mask, so nothing written afterwards changes the register. Only reset clears the lock.

Memory requests pass through the block on a valid/ready stream. Each accepted request is classified once and held in a single output slot. It leaves either on the forward stream, tagged with its route, or on the sink response stream. While the window is sealed, a request that falls in the window and does not come from SMM goes to the sink. A sink read returns all ones and a sink write is dropped. An SMM request that falls in the window is forwarded to the SMRAM route. A parameter removes the lock feature: the register then only stores bytes and never affects routing.

Back-pressure rules: a request is accepted on a cycle where `req_valid` and `req_ready` are both high. The source holds the request fields stable until it is accepted. An accepted request appears on exactly one output stream on the next cycle. It stays there with stable fields until the matching ready is high. `req_ready` is high when the slot is empty, or when the held item leaves in the same cycle.

Top module: `smbase_lock_guard`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x00, and `locked`, `sink_en` and `smm_win_en` are low.
- R2: In open mode (the state after reset), a write of any value other than 0xFF is discarded and `cfg_rd_data` stays 0x00. This includes values with bit 1 set, and such writes do not lock the window.
- R3: In open mode, a write of 0xFF sets `cfg_rd_data` to 0x01 on the next cycle and enters negotiated mode.
- R4: In negotiated mode, only bit 1 of a written byte is taken and the other bits keep the value 0x01. A write with bit 1 clear leaves 0x01. A write with bit 1 set (0x02 and 0xFF included) makes `cfg_rd_data` read exactly 0x02 and raises `locked`.
- R5: Once `locked` is high, no write of any value changes `cfg_rd_data` (0x02) or lowers `locked`, `sink_en` or `smm_win_en`; only reset clears them.
- R6: While `locked` is low, every accepted request is forwarded with `fwd_to_smram` = 0, and `sink_en` and `smm_win_en` are low.
- R7: While `locked` is high, a request with `req_smm` = 0 and an address in the window [0x30000, 0x50000) is not forwarded. It is answered on the response stream with `rsp_rdata` all ones, and a write's data is dropped.
- R8: While `locked` is high, a request with `req_smm` = 1 in the window is forwarded with `fwd_to_smram` = 1. Requests outside the window are always forwarded with `fwd_to_smram` = 0.
- R9: An accepted request is presented on exactly one output stream on the next cycle and is held with stable fields until its ready is high. `req_ready` equals (slot empty) or (held item leaving this cycle).
- R10: With the lock feature disabled, `cfg_rd_data` returns the last byte written, `locked` never rises, and all requests are forwarded with `fwd_to_smram` = 0.
- R11: Addresses 0x2FFFF and 0x50000 are outside the window and 0x30000 and 0x4FFFF are inside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Byte write strobe for the register |
| cfg_wr_data | input | 8 | Byte to write |
| cfg_rd_data | output | 8 | Current register value |
| locked | output | 1 | Window sealed |
| sink_en | output | 1 | Non-SMM accesses to the window are absorbed |
| smm_win_en | output | 1 | SMM accesses to the window reach RAM |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_smm | input | 1 | Request issued in SMM |
| req_wdata | input | DATA_W | Write data |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Downstream accepts the forwarded request |
| fwd_to_smram | output | 1 | 1 routes to SMRAM, 0 to the normal system path |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_wdata | output | DATA_W | Forwarded write data |
| rsp_valid | output | 1 | Sink response valid |
| rsp_ready | input | 1 | Requester accepts the sink response |
| rsp_rdata | output | DATA_W | Sink read data, all ones |

## Verification
The bench tries to lock the window from open mode by writing 0x02. A design that merged bits before discarding would seal the window too early. It writes 0xFF a second time after negotiation, where a design that treated the second query as a fresh handshake would show 0x01 instead of locking. Every byte value is written to a sealed register, so a mask that kept any writable bit would read back something other than 0x02 or would unlock. The window edges and a stalled stream with mixed sink and forward items expose off-by-one decoding, items leaking to both outputs, or fields changing under back-pressure.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  localparam logic [7:0] SMB_QUERY     = 8'hFF;
  localparam logic [7:0] SMB_ACK       = 8'h01;
  localparam int         SMB_LOCK_POS  = 1;
  localparam logic [7:0] SMB_LOCK      = 8'(1) << SMB_LOCK_POS;
  localparam logic [7:0] SMB_OPEN_MASK = 8'hFF;

  typedef enum logic [0:0] {
    TGT_SYS   = 1'b0,
    TGT_SMRAM = 1'b1
  } route_tgt_e;
endpackage

// File: rtl/smb_cfg_reg.sv
`timescale 1ns/1ps
module smb_cfg_reg
  import smb_pkg::*;
#(
  parameter bit FEATURE_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       locked
);

  generate
    if (FEATURE_EN) begin : g_lockable
      logic [7:0] val_q, val_d;
      logic [7:0] mask_q, mask_d;
      logic [7:0] merged;

      always_comb begin
        merged = (val_q & ~mask_q) | (wr_data & mask_q);
        val_d  = val_q;
        mask_d = mask_q;
        if (wr_en) begin
          if (merged == SMB_QUERY) begin
            val_d  = SMB_ACK;
            mask_d = SMB_LOCK;
          end else begin
            val_d = (mask_q == SMB_OPEN_MASK) ? 8'h00 : merged;
            if (|(val_d & SMB_LOCK)) begin
              val_d  = SMB_LOCK;
              mask_d = mask_q & ~SMB_LOCK;
            end
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q  <= 8'h00;
          mask_q <= SMB_OPEN_MASK;
        end else begin
          val_q  <= val_d;
          mask_q <= mask_d;
        end
      end

      assign rd_data = val_q;
      assign locked  = val_q[SMB_LOCK_POS];

      AST_OPEN_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == SMB_OPEN_MASK && wr_en && wr_data != SMB_QUERY) |=> (rd_data == 8'h00)); // R2
      AST_QUERY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == SMB_OPEN_MASK && wr_en && wr_data == SMB_QUERY) |=> (rd_data == SMB_ACK)); // R3
      AST_NEGOTIATED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == SMB_LOCK && wr_en && !wr_data[SMB_LOCK_POS]) |=> (rd_data == SMB_ACK)); // R4
      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && rd_data == SMB_LOCK)); // R5
    end else begin : g_plain
      logic [7:0] val_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     val_q <= 8'h00;
        else if (wr_en) val_q <= wr_data;
      end

      assign rd_data = val_q;
      assign locked  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/smb_win_match.sv
`timescale 1ns/1ps
module smb_win_match #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'('h30000),
  parameter logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'('h20000)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] OFS_MASK = WIN_SIZE - ADDR_W'(1);
  localparam logic [ADDR_W:0]   WIN_END  = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};
  localparam bit ALIGNED = ((WIN_SIZE & OFS_MASK) == '0) && ((WIN_BASE & OFS_MASK) == '0);

  generate
    if (ALIGNED) begin : g_mask_cmp
      assign hit = (addr & ~OFS_MASK) == WIN_BASE;
    end else begin : g_range_cmp
      assign hit = ({1'b0, addr} >= {1'b0, WIN_BASE}) && ({1'b0, addr} < WIN_END);
    end
  endgenerate

endmodule

// File: rtl/smb_route.sv
`timescale 1ns/1ps
module smb_route
  import smb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              in_win,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output route_tgt_e        fwd_tgt,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);

  typedef struct packed {
    logic              sink;
    route_tgt_e        tgt;
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic [DATA_W-1:0] wd;
  } slot_t;

  logic  slot_v;
  slot_t slot_q, slot_d;
  logic  guarded, leave, accept;

  assign guarded   = locked && in_win;
  assign leave     = slot_v && (slot_q.sink ? rsp_ready : fwd_ready);
  assign req_ready = !slot_v || leave;
  assign accept    = req_valid && req_ready;

  always_comb begin
    slot_d.sink = guarded && !req_smm;
    slot_d.tgt  = (guarded && req_smm) ? TGT_SMRAM : TGT_SYS;
    slot_d.addr = req_addr;
    slot_d.wr   = req_write;
    slot_d.wd   = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= 1'b0;
      slot_q <= '0;
    end else if (accept) begin
      slot_v <= 1'b1;
      slot_q <= slot_d;
    end else if (leave) begin
      slot_v <= 1'b0;
    end
  end

  assign fwd_valid = slot_v && !slot_q.sink;
  assign fwd_tgt   = slot_q.tgt;
  assign fwd_addr  = slot_q.addr;
  assign fwd_write = slot_q.wr;
  assign fwd_wdata = slot_q.wd;
  assign rsp_valid = slot_v && slot_q.sink;
  assign rsp_rdata = {DATA_W{1'b1}};

  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_wdata) && $stable(fwd_tgt))); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid); // R9
  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, rsp_valid})); // R9
  AST_SINK_WHEN_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> locked); // R7
  AST_SMRAM_WHEN_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_tgt == TGT_SMRAM) |-> locked); // R8

endmodule

// File: rtl/smbase_lock_guard.sv
`timescale 1ns/1ps
module smbase_lock_guard
  import smb_pkg::*;
#(
  parameter bit                FEATURE_EN = 1'b1,
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = ADDR_W'('h30000),
  parameter logic [ADDR_W-1:0] WIN_SIZE   = ADDR_W'('h20000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_data,
  output logic [7:0]        cfg_rd_data,
  output logic              locked,
  output logic              sink_en,
  output logic              smm_win_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_smm,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic              fwd_to_smram,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic       seal;
  logic       in_win;
  route_tgt_e tgt;

  smb_cfg_reg #(.FEATURE_EN(FEATURE_EN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .locked  (seal)
  );

  smb_win_match #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_win (
    .addr (req_addr),
    .hit  (in_win)
  );

  smb_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (seal),
    .in_win    (in_win),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_smm   (req_smm),
    .req_wdata (req_wdata),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_tgt   (tgt),
    .fwd_addr  (fwd_addr),
    .fwd_write (fwd_write),
    .fwd_wdata (fwd_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  assign locked       = seal;
  assign sink_en      = seal;
  assign smm_win_en   = seal;
  assign fwd_to_smram = (tgt == TGT_SMRAM);

  AST_OUTPUTS_TRACK_SEAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sink_en) |-> (cfg_rd_data == 8'h02 && smm_win_en)); // R4

endmodule

// File: tb/tb_smbase_lock_guard.sv
`timescale 1ns/1ps
module tb_smbase_lock_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_wr_en = 0;
  logic [7:0]  cfg_wr_data = 0;
  logic [7:0]  cfg_rd_data;
  logic        locked, sink_en, smm_win_en;
  logic        req_valid = 0, req_write = 0, req_smm = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic        req_ready;
  logic        fwd_valid, fwd_to_smram, fwd_write;
  logic [31:0] fwd_addr, fwd_wdata, rsp_rdata;
  logic        fwd_ready = 1, rsp_ready = 1, rsp_valid;

  logic        o_wr_en = 0;
  logic [7:0]  o_wr_data = 0;
  logic [7:0]  o_rd_data;
  logic        o_locked, o_sink_en, o_smm_win_en;
  logic        o_req_valid = 0;
  logic [31:0] o_req_addr = 0;
  logic        o_req_ready, o_fwd_valid, o_fwd_to_smram, o_fwd_write, o_rsp_valid;
  logic [31:0] o_fwd_addr, o_fwd_wdata, o_rsp_rdata;

  smbase_lock_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .locked(locked), .sink_en(sink_en), .smm_win_en(smm_win_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_smm(req_smm), .req_wdata(req_wdata), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_to_smram(fwd_to_smram), .fwd_addr(fwd_addr), .fwd_write(fwd_write),
    .fwd_wdata(fwd_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  smbase_lock_guard #(.FEATURE_EN(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(o_wr_en), .cfg_wr_data(o_wr_data),
    .cfg_rd_data(o_rd_data), .locked(o_locked), .sink_en(o_sink_en), .smm_win_en(o_smm_win_en),
    .req_valid(o_req_valid), .req_ready(o_req_ready), .req_addr(o_req_addr), .req_write(1'b0),
    .req_smm(1'b0), .req_wdata(32'h0), .fwd_valid(o_fwd_valid), .fwd_ready(1'b1),
    .fwd_to_smram(o_fwd_to_smram), .fwd_addr(o_fwd_addr), .fwd_write(o_fwd_write),
    .fwd_wdata(o_fwd_wdata), .rsp_valid(o_rsp_valid), .rsp_ready(1'b1), .rsp_rdata(o_rsp_rdata)
  );

  int n_checks = 0;
  int n_fails  = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: mode 0 open, 1 negotiated, 2 sealed
  typedef struct {
    bit          sink;
    bit          smram;
    logic [31:0] addr;
    bit          wr;
    logic [31:0] wd;
  } exp_t;
  exp_t q[$];
  int   mode = 0;

  function automatic bit in_window(logic [31:0] a);
    return (a >= 32'h30000) && (a < 32'h50000);
  endfunction

  always @(negedge clk) begin
    int  exp_val;
    bit  sealed, has, leave_ok, rdy;
    exp_t it;
    if (!rst_n) begin
      mode = 0;
      q.delete();
    end
    exp_val = (mode == 0) ? 0 : (mode == 1) ? 1 : 2;
    sealed  = (mode == 2);
    chk(cur_tag, "cfg_rd_data", cfg_rd_data, exp_val);
    chk(cur_tag, "locked", locked, sealed);
    chk(cur_tag, "sink_en", sink_en, sealed);
    chk(cur_tag, "smm_win_en", smm_win_en, sealed);
    has      = q.size() > 0;
    leave_ok = has && (q[0].sink ? rsp_ready : fwd_ready);
    rdy      = !has || leave_ok;
    chk("R9", "req_ready", req_ready, rdy);
    chk("R9", "fwd_valid", fwd_valid, has && !q[0].sink);
    chk("R9", "rsp_valid", rsp_valid, has && q[0].sink);
    if (has && !q[0].sink) begin
      chk(cur_tag, "fwd_to_smram", fwd_to_smram, q[0].smram);
      chk(cur_tag, "fwd_addr", fwd_addr, q[0].addr);
      chk(cur_tag, "fwd_write", fwd_write, q[0].wr);
      chk(cur_tag, "fwd_wdata", fwd_wdata, q[0].wd);
    end
    if (has && q[0].sink) chk(cur_tag, "rsp_rdata", rsp_rdata, 32'hFFFF_FFFF);
    if (rst_n) begin
      if (leave_ok) void'(q.pop_front());
      if (req_valid && rdy) begin
        it.sink  = sealed && in_window(req_addr) && !req_smm;
        it.smram = sealed && in_window(req_addr) && req_smm;
        it.addr  = req_addr;
        it.wr    = req_write;
        it.wd    = req_wdata;
        q.push_back(it);
      end
      if (cfg_wr_en) begin
        case (mode)
          0: mode = (cfg_wr_data == 8'hFF) ? 1 : 0;
          1: mode = cfg_wr_data[1] ? 2 : 1;
          default: mode = 2;
        endcase
      end
    end
  end

  int rdy_mode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #2;
    cyc++;
    if (rdy_mode == 0) begin
      fwd_ready = 1'b1;
      rsp_ready = 1'b1;
    end else begin
      fwd_ready = (cyc % 3) != 0;
      rsp_ready = (cyc % 4) != 1;
    end
  end

  task automatic cfg_write(logic [7:0] b);
    @(posedge clk); #2;
    cfg_wr_en = 1'b1; cfg_wr_data = b;
    @(posedge clk); #2;
    cfg_wr_en = 1'b0;
  endtask

  task automatic send(logic [31:0] a, logic wr, logic smm);
    @(posedge clk); #2;
    req_valid = 1'b1; req_addr = a; req_write = wr; req_smm = smm; req_wdata = a ^ 32'h5A5A_0000;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic burst(int n, logic [31:0] start, logic [31:0] step);
    @(posedge clk); #2;
    for (int i = 0; i < n; i++) begin
      req_valid = 1'b1;
      req_addr  = start + i * step;
      req_smm   = i[0];
      req_write = i[1];
      req_wdata = 32'hA500 + i;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #2;
    end
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic off_write(logic [7:0] b);
    @(posedge clk); #2;
    o_wr_en = 1'b1; o_wr_data = b;
    @(posedge clk); #2;
    o_wr_en = 1'b0;
    @(negedge clk);
    chk("R10", "off rd_data", o_rd_data, b);
    chk("R10", "off locked", o_locked, 1'b0);
    chk("R10", "off sink_en", o_sink_en | o_smm_win_en, 1'b0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    cur_tag = "R6";
    send(32'h30000, 1'b0, 1'b0);
    send(32'h3FFFC, 1'b1, 1'b0);
    send(32'h30010, 1'b0, 1'b1);
    send(32'h00100, 1'b0, 1'b0);

    cur_tag = "R2";
    cfg_write(8'h02);
    cfg_write(8'h55);
    cfg_write(8'hFE);
    cfg_write(8'h00);
    send(32'h30000, 1'b0, 1'b0);

    cur_tag = "R3";
    cfg_write(8'hFF);

    cur_tag = "R4";
    cfg_write(8'h01);
    cfg_write(8'hFD);
    cfg_write(8'h00);
    cfg_write(8'h02);

    cur_tag = "R7";
    rdy_mode = 1;
    send(32'h30000, 1'b0, 1'b0);
    send(32'h44444, 1'b1, 1'b0);
    send(32'h4FFF0, 1'b0, 1'b0);

    cur_tag = "R8";
    send(32'h30000, 1'b0, 1'b1);
    send(32'h48000, 1'b1, 1'b1);
    send(32'h10000, 1'b0, 1'b1);
    send(32'h60000, 1'b0, 1'b0);

    cur_tag = "R11";
    send(32'h2FFFF, 1'b0, 1'b0);
    send(32'h30000, 1'b0, 1'b0);
    send(32'h4FFFF, 1'b0, 1'b0);
    send(32'h50000, 1'b0, 1'b0);

    cur_tag = "R9";
    burst(24, 32'h28000, 32'h2000);
    rdy_mode = 0;
    burst(8, 32'h2C000, 32'h4000);

    cur_tag = "R5";
    for (int b = 0; b < 256; b++) cfg_write(8'(b));
    send(32'h38000, 1'b0, 1'b0);

    cur_tag = "R1";
    do_reset();
    repeat (2) @(posedge clk);

    cur_tag = "R4";
    cfg_write(8'hFF);
    cfg_write(8'hFF);
    send(32'h30000, 1'b0, 1'b0);

    cur_tag = "R1";
    do_reset();
    cur_tag = "R2";
    cfg_write(8'h02);
    cfg_write(8'h02);
    send(32'h30000, 1'b1, 1'b0);

    off_write(8'hFF);
    off_write(8'h02);
    off_write(8'h5C);
    @(posedge clk); #2;
    o_req_valid = 1'b1; o_req_addr = 32'h30000;
    @(posedge clk); #2;
    o_req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "off fwd_valid", o_fwd_valid, 1'b1);
    chk("R10", "off fwd_to_smram", o_fwd_to_smram, 1'b0);
    chk("R10", "off fwd_addr", o_fwd_addr, 32'h30000);
    chk("R10", "off rsp_valid", o_rsp_valid, 1'b0);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule